// File: doc/BRIEF.md
# Shared Last-Level Cache Tag Controller with Selective Back-Invalidation

This block is the tag and state side of a set-associative cache shared by two cores. Each core's private first-level cache sends it requests for one 4-byte block, carrying the requesting core's number and an inclusion attribute that address translation has already resolved for the page. The block looks the address up, reports a hit or a miss, and on a miss allocates a way by least-recently-used replacement. Data storage, memory timing, the private caches and translation all sit outside it.

Each line records whether it must remain inclusive. A line filled by a request with the inclusion attribute clear is marked removable. When such a line is chosen as a victim, it is dropped with no message to the private caches. A line that must stay inclusive (writable shared data, and run-time allocated data treated the same way) has each core that may hold a copy told to invalidate it before the way is reused. Per-core presence bits narrow those commands to the cores that actually touched the line. The shared capacity defaults to four times the combined private capacity, and the associativity may be 2, 4 or 8.

Top module: `llc_selective_inval`

## Requirements
- R1: A request reports `rsp_hit` = 1 exactly when its block address is held in a valid line of the indexed set (set = low `SET_W` address bits, tag = remaining bits).
- R2: On a miss the block is allocated into the lowest-numbered invalid way of the set. If every way is valid, it goes into the least recently used way. `rsp_evict` is 1 only when a valid line was displaced, and `rsp_evict_addr` then gives that line's block address.
- R3: Every hit and every fill makes the touched way the most recently used of its set.
- R4: A fill stores removable = NOT `req_incl`. Evicting a removable line raises no `inv_valid` bit.
- R5: Evicting a non-removable line raises `inv_valid[c]` for each core c whose presence bit is set, with `inv_addr` equal to the victim's block address, and for no other core.
- R6: A line's presence bit for core c is set when core c fills it or hits it. Presence is cleared only when the line is replaced.
- R7: A hit with `req_incl` = 1 clears the line's removable bit. A hit with `req_incl` = 0 leaves it unchanged.
- R8: Each `inv_valid[c]` stays high, with `inv_addr` stable, until a cycle in which `inv_ack[c]` is high. `req_ready` is low while any invalidation is outstanding, and the response follows only after all of them are acknowledged.
- R9: `rsp_valid` is a one-cycle pulse. With no invalidation it rises in the second cycle after the request is accepted.
- R10: After reset all lines are invalid, `req_ready` is 1, and `rsp_valid` and `inv_valid` are 0.
- R11: One request is in flight at a time: `req_ready` is low from the cycle after acceptance until the cycle after the response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Block address of the request |
| req_core | input | CORE_W | Requesting core number |
| req_incl | input | 1 | 1 = page requires inclusion (shared writable or run-time data) |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_evict | output | 1 | A valid line was displaced by this miss |
| rsp_evict_addr | output | ADDR_W | Block address of the displaced line |
| inv_valid | output | NCORE | Per-core back-invalidation command |
| inv_addr | output | ADDR_W | Block address to invalidate |
| inv_ack | input | NCORE | Per-core acknowledge of the invalidation |

## Verification
The assertions assume that `inv_ack[c]` is only raised for one cycle while `inv_valid[c]` is high, and that requests are presented only while `req_ready` is high and held for the accepting edge. The bench drives acknowledges from a process that responds only to a visible command, after a delay of 0 to 3 cycles, and drops the acknowledge on the following cycle. It issues each request only when the block is idle. Both requirements on silent drops and targeted invalidation are checked by recording every command seen on the invalidation port for each request and comparing the set of cores and the address against a list-based replacement model.

// File: rtl/llc_sel_pkg.sv
package llc_sel_pkg;

    localparam int NCORE  = 2;
    localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1;

    localparam int DEF_ADDR_W    = 16;
    localparam int DEF_L1_BLOCKS = 16;
    localparam int DEF_SCALE     = 4;
    localparam int DEF_WAYS      = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_INVAL = 2'd2,
        ST_RESP  = 2'd3
    } llc_state_e;

    typedef struct packed {
        logic             valid;
        logic             removable;
        logic [NCORE-1:0] present;
    } llc_meta_t;

    function automatic logic [NCORE-1:0] core_bit(input logic [CORE_W-1:0] c);
        logic [NCORE-1:0] r;
        r = '0;
        r[c] = 1'b1;
        return r;
    endfunction

    function automatic llc_meta_t fresh_line(input logic [CORE_W-1:0] c,
                                             input logic incl);
        llc_meta_t m;
        m.valid     = 1'b1;
        m.removable = ~incl;
        m.present   = core_bit(c);
        return m;
    endfunction

endpackage

// File: rtl/llc_tag_store.sv
module llc_tag_store
    import llc_sel_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int SET_W = 5,
    parameter int WAY_W = 2,
    parameter int TAG_W = 11
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [SET_W-1:0]            set_idx,
    output llc_meta_t [WAYS-1:0]        rd_meta,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  llc_meta_t                   wr_meta,
    input  logic [TAG_W-1:0]            wr_tag
);

    llc_meta_t        meta_q [SETS][WAYS];
    logic [TAG_W-1:0] tag_q  [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    meta_q[s][w] <= '0;
                end
            end
        end else if (wr_en) begin
            meta_q[set_idx][wr_way] <= wr_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[set_idx][wr_way] <= wr_tag;
        end
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_rd
            assign rd_meta[w] = meta_q[set_idx][w];
            assign rd_tag[w]  = tag_q[set_idx][w];
        end
    endgenerate

endmodule

// File: rtl/llc_lru_store.sv
module llc_lru_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 4,
    parameter int SET_W = 5,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    // age 0 = most recent, WAYS-1 = least recent; ages form a permutation
    logic [WAY_W-1:0] age_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[set_idx][w] < age_q[set_idx][touch_way]) begin
                    age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
                end
            end
            age_q[set_idx][touch_way] <= '0;
        end
    end

    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[set_idx][w] == OLDEST) begin
                    victim_way = WAY_W'(w);
                end
            end
        end
    end

endmodule

// File: rtl/llc_selective_inval.sv
module llc_selective_inval
    import llc_sel_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int L1_BLOCKS = DEF_L1_BLOCKS,
    parameter int SCALE     = DEF_SCALE,
    parameter int WAYS      = DEF_WAYS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CORE_W-1:0] req_core,
    input  logic              req_incl,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_evict,
    output logic [ADDR_W-1:0] rsp_evict_addr,
    output logic [NCORE-1:0]  inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic [NCORE-1:0]  inv_ack
);

    localparam int LLC_BLOCKS = L1_BLOCKS * NCORE * SCALE;
    localparam int SETS       = LLC_BLOCKS / WAYS;
    localparam int SET_W      = $clog2(SETS);
    localparam int WAY_W      = $clog2(WAYS);
    localparam int TAG_W      = ADDR_W - SET_W;

    llc_state_e        st_q;
    logic [SET_W-1:0]  rq_set_q;
    logic [TAG_W-1:0]  rq_tag_q;
    logic [CORE_W-1:0] rq_core_q;
    logic              rq_incl_q;
    logic [WAY_W-1:0]  vic_way_q;
    logic [NCORE-1:0]  pend_q;
    logic [ADDR_W-1:0] inv_addr_q;
    logic              rsp_hit_q;
    logic              rsp_evict_q;
    logic [ADDR_W-1:0] rsp_evict_addr_q;

    llc_meta_t [WAYS-1:0]       rd_meta;
    logic [WAYS-1:0][TAG_W-1:0] rd_tag;
    logic [WAYS-1:0]            way_valid;
    logic [WAYS-1:0]            way_match;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           vic_way;
    llc_meta_t                  vic_meta;
    logic [ADDR_W-1:0]          vic_addr;
    logic                       need_inv;
    logic                       evict_silent;

    logic             wr_en;
    logic [WAY_W-1:0] wr_way;
    llc_meta_t        wr_meta;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign way_valid[w] = rd_meta[w].valid;
            assign way_match[w] = rd_meta[w].valid && (rd_tag[w] == rq_tag_q);
        end
    endgenerate

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit      = |way_match;
    assign vic_meta = rd_meta[vic_way];
    assign vic_addr = {rd_tag[vic_way], rq_set_q};
    assign need_inv = !hit && vic_meta.valid && !vic_meta.removable && (|vic_meta.present);

    llc_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
    ) tags_i (
        .clk     (clk),
        .rst     (rst),
        .set_idx (rq_set_q),
        .rd_meta (rd_meta),
        .rd_tag  (rd_tag),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_meta (wr_meta),
        .wr_tag  (rq_tag_q)
    );

    llc_lru_store #(
        .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)
    ) lru_i (
        .clk        (clk),
        .rst        (rst),
        .set_idx    (rq_set_q),
        .way_valid  (way_valid),
        .victim_way (vic_way),
        .touch_en   (touch_en),
        .touch_way  (touch_way)
    );

    // array update decisions
    always_comb begin
        wr_en        = 1'b0;
        wr_way       = vic_way;
        wr_meta      = fresh_line(rq_core_q, rq_incl_q);
        touch_en     = 1'b0;
        touch_way    = vic_way;
        evict_silent = 1'b0;
        case (st_q)
            ST_LOOK: begin
                if (hit) begin
                    wr_en             = 1'b1;
                    wr_way            = hit_way;
                    wr_meta           = rd_meta[hit_way];
                    wr_meta.removable = rd_meta[hit_way].removable & ~rq_incl_q;
                    wr_meta.present   = rd_meta[hit_way].present | core_bit(rq_core_q);
                    touch_en          = 1'b1;
                    touch_way         = hit_way;
                end else if (!need_inv) begin
                    wr_en        = 1'b1;
                    touch_en     = 1'b1;
                    evict_silent = vic_meta.valid && vic_meta.removable;
                end
            end
            ST_INVAL: begin
                if (pend_q == '0) begin
                    wr_en     = 1'b1;
                    wr_way    = vic_way_q;
                    touch_en  = 1'b1;
                    touch_way = vic_way_q;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q             <= ST_IDLE;
            rq_set_q         <= '0;
            rq_tag_q         <= '0;
            rq_core_q        <= '0;
            rq_incl_q        <= 1'b0;
            vic_way_q        <= '0;
            pend_q           <= '0;
            inv_addr_q       <= '0;
            rsp_hit_q        <= 1'b0;
            rsp_evict_q      <= 1'b0;
            rsp_evict_addr_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq_set_q  <= req_addr[SET_W-1:0];
                        rq_tag_q  <= req_addr[ADDR_W-1:SET_W];
                        rq_core_q <= req_core;
                        rq_incl_q <= req_incl;
                        st_q      <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    rsp_hit_q <= hit;
                    if (hit) begin
                        rsp_evict_q <= 1'b0;
                        st_q        <= ST_RESP;
                    end else begin
                        rsp_evict_q      <= vic_meta.valid;
                        rsp_evict_addr_q <= vic_addr;
                        if (need_inv) begin
                            pend_q     <= vic_meta.present;
                            inv_addr_q <= vic_addr;
                            vic_way_q  <= vic_way;
                            st_q       <= ST_INVAL;
                        end else begin
                            st_q <= ST_RESP;
                        end
                    end
                end
                ST_INVAL: begin
                    if (pend_q == '0) begin
                        st_q <= ST_RESP;
                    end else begin
                        pend_q <= pend_q & ~inv_ack;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready      = (st_q == ST_IDLE);
    assign rsp_valid      = (st_q == ST_RESP);
    assign rsp_hit        = rsp_hit_q;
    assign rsp_evict      = rsp_evict_q;
    assign rsp_evict_addr = rsp_evict_addr_q;
    assign inv_valid      = (st_q == ST_INVAL) ? pend_q : '0;
    assign inv_addr       = inv_addr_q;

endmodule

// File: rtl/llc_sel_checker.sv
module llc_sel_checker
    import llc_sel_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [NCORE-1:0]  inv_valid,
    input logic [NCORE-1:0]  inv_ack,
    input logic [ADDR_W-1:0] inv_addr,
    input logic              evict_silent
);

    // R8
    inv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((inv_valid & ~inv_ack) != '0) |=> (($past(inv_valid & ~inv_ack) & ~inv_valid) == '0));

    // R8
    inv_addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ((inv_valid & ~inv_ack) != '0) |=> $stable(inv_addr));

    // R8
    inv_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (inv_valid != '0) |-> !req_ready);

    // R8
    rsp_after_inv_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (inv_valid == '0));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4
    silent_evict_chk: assert property (@(posedge clk) disable iff (rst)
        evict_silent |=> (inv_valid == '0));

endmodule

bind llc_selective_inval llc_sel_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .inv_valid    (inv_valid),
    .inv_ack      (inv_ack),
    .inv_addr     (inv_addr),
    .evict_silent (evict_silent)
);

// File: tb/llc_selective_inval_tb.sv
`timescale 1ns/1ps
module llc_selective_inval_tb_top;
    import llc_sel_pkg::*;

    localparam int AW     = 16;
    localparam int L1B    = 16;
    localparam int SC     = 4;
    localparam int WAYS   = 4;
    localparam int SETS   = (L1B * NCORE * SC) / WAYS;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = AW - SET_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [AW-1:0]     req_addr = '0;
    logic [CORE_W-1:0] req_core = '0;
    logic              req_incl = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_evict;
    logic [AW-1:0]     rsp_evict_addr;
    logic [NCORE-1:0]  inv_valid;
    logic [AW-1:0]     inv_addr;
    logic [NCORE-1:0]  inv_ack = '0;

    always #2.5 clk = ~clk;

    llc_selective_inval #(.ADDR_W(AW), .L1_BLOCKS(L1B), .SCALE(SC), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_core(req_core), .req_incl(req_incl),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_evict(rsp_evict),
        .rsp_evict_addr(rsp_evict_addr),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] lfsr = 32'h1ACE_0F5D;

    // reference model: per-set recency list, position 0 = most recent
    bit               m_v    [SETS][WAYS];
    logic [TAG_W-1:0] m_tag  [SETS][WAYS];
    bit               m_rmv  [SETS][WAYS];
    bit [NCORE-1:0]   m_pres [SETS][WAYS];
    int               m_ord  [SETS][WAYS];

    // invalidation observer state
    bit [NCORE-1:0] rec_mask;
    logic [AW-1:0]  rec_addr [NCORE];
    int             ack_wait [NCORE];

    function automatic logic [31:0] step(input logic [31:0] x);
        return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic touch(input int s, input int w);
        int p = 0;
        for (int i = 0; i < WAYS; i++) if (m_ord[s][i] == w) p = i;
        for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
        m_ord[s][0] = w;
    endtask

    always @(negedge clk) begin
        for (int c = 0; c < NCORE; c++) begin
            if (inv_ack[c]) begin
                inv_ack[c] = 1'b0;
            end else if (inv_valid[c]) begin
                rec_mask[c] = 1'b1;
                rec_addr[c] = inv_addr;
                if (ack_wait[c] == 0) inv_ack[c] = 1'b1;
                else ack_wait[c]--;
            end
        end
    end

    task automatic do_req(input int tag, input int set, input int core, input bit incl);
        bit             e_hit = 0, e_ev = 0;
        bit [NCORE-1:0] e_mask = '0;
        logic [AW-1:0]  e_addr = '0;
        int             vw = -1, n = 0;
        bit             got = 0, busy_bad = 0;
        bit             a_hit = 0, a_ev = 0;
        logic [AW-1:0]  a_addr = '0;

        for (int w = 0; w < WAYS; w++)
            if (m_v[set][w] && m_tag[set][w] == TAG_W'(tag)) begin e_hit = 1; vw = w; end
        if (e_hit) begin
            m_pres[set][vw][core] = 1'b1;
            if (incl) m_rmv[set][vw] = 1'b0;
            touch(set, vw);
        end else begin
            for (int w = 0; w < WAYS; w++) if (!m_v[set][w] && vw < 0) vw = w;
            if (vw < 0) vw = m_ord[set][WAYS-1];
            e_ev   = m_v[set][vw];
            e_addr = {m_tag[set][vw], SET_W'(set)};
            e_mask = (e_ev && !m_rmv[set][vw]) ? m_pres[set][vw] : '0;
            m_v[set][vw]    = 1'b1;
            m_tag[set][vw]  = TAG_W'(tag);
            m_rmv[set][vw]  = !incl;
            m_pres[set][vw] = '0;
            m_pres[set][vw][core] = 1'b1;
            touch(set, vw);
        end

        @(negedge clk);
        rec_mask = '0;
        for (int c = 0; c < NCORE; c++) begin
            lfsr = step(lfsr);
            ack_wait[c] = int'(lfsr[1:0]);
        end
        req_addr  = {TAG_W'(tag), SET_W'(set)};
        req_core  = CORE_W'(core);
        req_incl  = incl;
        req_valid = 1'b1;
        @(posedge clk);
        while (!got && n < 100) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                req_valid = 1'b0;
                check(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
            end
            if (inv_valid != '0 && req_ready) busy_bad = 1;
            if (rsp_valid) begin
                got = 1; a_hit = rsp_hit; a_ev = rsp_evict; a_addr = rsp_evict_addr;
            end
        end
        check(got, "R9 response seen", got, 1);
        if (e_mask == '0) check(n == 2, "R9 response latency", n, 2);
        else check(n > 2, "R8 response after acks", n, 3);
        check(a_hit == e_hit, "R1 hit/miss", a_hit, e_hit);
        check(a_ev == e_ev, "R2 evict flag", a_ev, e_ev);
        if (e_ev) check(a_addr == e_addr, "R2 evict address", a_addr, e_addr);
        if (e_ev && e_mask == '0)
            check(rec_mask == '0, "R4 silent removable eviction", rec_mask, 0);
        else
            check(rec_mask == e_mask, "R5 R6 invalidation targets", rec_mask, e_mask);
        for (int c = 0; c < NCORE; c++)
            if (e_mask[c]) check(rec_addr[c] == e_addr, "R5 invalidation address", rec_addr[c], e_addr);
        check(!busy_bad, "R8 ready low during invalidation", busy_bad, 0);
        @(negedge clk);
        check(req_ready && !rsp_valid, "R9 R11 pulse ends, ready back", {req_ready, rsp_valid}, 2);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_v[s][w] = 0; m_rmv[s][w] = 0; m_pres[s][w] = '0; m_ord[s][w] = w; m_tag[s][w] = '0;
            end
        for (int c = 0; c < NCORE; c++) begin ack_wait[c] = 0; rec_addr[c] = '0; end
        rec_mask = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R10 no response after reset", rsp_valid, 0);
        check(inv_valid == '0, "R10 no invalidation after reset", inv_valid, 0);

        // directed walk through one set
        do_req(1, 5, 0, 0);   // R2 fill, removable
        do_req(1, 5, 1, 1);   // R7 inclusive hit clears removable, R6 core1 present
        do_req(2, 5, 0, 0);
        do_req(3, 5, 1, 0);
        do_req(4, 5, 0, 0);
        do_req(2, 5, 1, 0);   // R3 recency update by hit
        do_req(5, 5, 0, 1);   // R5 victim tag1, both cores invalidated
        do_req(6, 5, 1, 0);   // R4 removable victim dropped silently
        do_req(7, 5, 1, 0);
        do_req(8, 5, 0, 0);   // victim tag2 removable with two sharers, still silent
        do_req(9, 5, 1, 0);   // R6 victim tag5 present only in core0
        do_req(9, 5, 0, 0);   // R7 non-inclusive hit keeps removable

        // sweep over a few sets with heavy conflict
        for (int i = 0; i < 3000; i++) begin
            lfsr = step(lfsr);
            do_req(int'(lfsr[4:2]), int'(lfsr[9:8]), int'(lfsr[12]), lfsr[17] & lfsr[5]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule